// File: doc/BRIEF.md
# Management Bus Address Window

This block is the responder-side address decoder of a switch attached to a shared management bus. Each management register access arrives already deframed: a 5-bit bus address, a 5-bit register number, a read/write flag and 16 bits of write data. The block decides from its strap inputs whether it answers the access at all. It then either forwards the access straight to an internal device or handles it through a two-register indirect window. Internal devices are modelled as a small register store.

Three addressing schemes exist. With all strap bits low on a single-window build, every one of the 32 bus addresses maps one-to-one onto an internal device. With any strap bit high, the block answers only at the even address formed by the straps. There it offers a command register and a data register, and it runs the internal transfer that a command with its busy flag set starts. Busy clears by itself after a fixed number of cycles. A build with the `DUAL_WINDOW` parameter set looks only at the top strap bit and answers a block of 16 consecutive addresses, so two such switches can share one bus.

Top module: `smi_addr_window`

## Requirements
- R1: Single-window build, straps all zero: an access at bus address P and register N reaches internal device P, register N. A written value reads back unchanged at every address from 0 to 31.
- R2: Single-window build, straps non-zero: only the bus address {strap_hi, 0} is answered. Reads at any other address return 16'hFFFF, and writes there change no state.
- R3: The command word layout is: bit 15 busy, bit 12 Clause-22 enable, bits 11:10 opcode (01 write, 10 read), bits 9:5 internal device, bits 4:0 internal register. Reading the command register returns the stored bits 14:0 with the live busy flag in bit 15.
- R4: Indirect write: write the data register (register 1), then write the command register (register 0) with busy set, Clause-22 set and opcode 01. The data value then lands in the addressed internal register.
- R5: Indirect read: write a command with busy set, Clause-22 set and opcode 10. Once busy has cleared, the data register holds the addressed internal register value.
- R6: A command written with bit 15 set makes busy read as 1 on exactly BUSY_CYCLES back-to-back reads of the command register that follow it. It reads as 0 from the next read on, without any further write.
- R7: While busy is set, writes to the command register and to the data register are ignored.
- R8: After reset, busy, the stored command, the data register and every internal register read as zero.
- R9: Dual-window build: only strap_hi[3] counts. The block answers bus addresses base to base+15, with base 16 when strap_hi[3] is 1 and 0 otherwise. The internal device is the bus address minus base. Other addresses read 16'hFFFF and ignore writes.
- R10: Every read access produces exactly one response, with rsp_valid high, in the cycle after the access is sampled. Writes produce none.
- R11: In the indirect window, register numbers 2 to 31 read 16'hFFFF and ignore writes.
- R12: Each internal device holds 2**STORE_REG_W registers, default 4. The register number is taken modulo that count, so with the default, register 6 and register 2 of the same device are one storage cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_hi | input | 4 | Strapped address bits 4:1 (bit 0 is always zero) |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_phy | input | 5 | Bus address of the access |
| acc_reg | input | 5 | Register number of the access |
| acc_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response is valid |
| rsp_data | output | 16 | Read response data |

## Verification
Read results are due one cycle after the clock edge that samples the access. The bench therefore queues an expected value when it issues a read, and pops it at the falling edge in which rsp_valid is seen. Indirect transfers finish BUSY_CYCLES edges after the command is sampled. The busy check issues reads of the command register on consecutive cycles and expects exactly BUSY_CYCLES of them with bit 15 set. The checks on the data register are placed after enough idle cycles for the transfer to have completed.

// File: rtl/smi_win_pkg.sv
package smi_win_pkg;

  localparam int unsigned SMI_DATA_W = 16;
  localparam int unsigned SMI_ADDR_W = 5;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10,
    OP_RSV  = 2'b11
  } c22_op_e;

  typedef struct packed {
    logic                  busy;
    logic [1:0]            rsvd;
    logic                  c22;
    c22_op_e               op;
    logic [SMI_ADDR_W-1:0] dev;
    logic [SMI_ADDR_W-1:0] regn;
  } cmd_word_t;

  localparam logic [SMI_ADDR_W-1:0] WIN_CMD_REG  = 5'd0;
  localparam logic [SMI_ADDR_W-1:0] WIN_DATA_REG = 5'd1;
  localparam logic [SMI_DATA_W-1:0] NO_ANSWER    = '1;

endpackage

// File: rtl/smi_win_decode.sv
module smi_win_decode
  import smi_win_pkg::*;
#(
  parameter bit DUAL_WINDOW = 1'b0
) (
  input  logic [SMI_ADDR_W-2:0] strap_hi,
  input  logic [SMI_ADDR_W-1:0] acc_phy,
  output logic                  hit_direct,
  output logic                  hit_window,
  output logic [SMI_ADDR_W-1:0] dev_idx
);

  generate
    if (DUAL_WINDOW) begin : g_dual
      logic unused_strap;
      assign unused_strap = ^strap_hi[SMI_ADDR_W-3:0];
      // Window of half the address space, selected by the top strap bit.
      assign hit_direct = (acc_phy[SMI_ADDR_W-1] == strap_hi[SMI_ADDR_W-2]);
      assign hit_window = 1'b0;
      assign dev_idx    = {1'b0, acc_phy[SMI_ADDR_W-2:0]};
    end else begin : g_single
      logic all_zero;
      assign all_zero   = (strap_hi == '0);
      assign hit_direct = all_zero;
      assign hit_window = !all_zero && (acc_phy == {strap_hi, 1'b0});
      assign dev_idx    = acc_phy;
    end
  endgenerate

endmodule

// File: rtl/smi_win_regs.sv
module smi_win_regs
  import smi_win_pkg::*;
#(
  parameter int unsigned STORE_REG_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [SMI_ADDR_W-1:0]  wdev,
  input  logic [STORE_REG_W-1:0] wreg,
  input  logic [SMI_DATA_W-1:0]  wdata,
  input  logic [SMI_ADDR_W-1:0]  a_dev,
  input  logic [STORE_REG_W-1:0] a_reg,
  output logic [SMI_DATA_W-1:0]  a_rdata,
  input  logic [SMI_ADDR_W-1:0]  b_dev,
  input  logic [STORE_REG_W-1:0] b_reg,
  output logic [SMI_DATA_W-1:0]  b_rdata
);

  localparam int unsigned IDX_W   = SMI_ADDR_W + STORE_REG_W;
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [SMI_DATA_W-1:0] mem_q [ENTRIES];
  logic [IDX_W-1:0]      widx;

  assign widx    = {wdev, wreg};
  assign a_rdata = mem_q[{a_dev, a_reg}];
  assign b_rdata = mem_q[{b_dev, b_reg}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[widx] <= wdata;
    end
  end

endmodule

// File: rtl/smi_win_engine.sv
module smi_win_engine
  import smi_win_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_wr,
  input  logic                  data_wr,
  input  logic [SMI_DATA_W-1:0] wdata,
  input  logic [SMI_DATA_W-1:0] dev_rdata,
  output logic [SMI_DATA_W-1:0] cmd_rdata,
  output logic [SMI_DATA_W-1:0] data_rdata,
  output logic                  xfer_we,
  output logic [SMI_ADDR_W-1:0] xfer_dev,
  output logic [SMI_ADDR_W-1:0] xfer_reg,
  output logic                  busy
);

  localparam int unsigned     CNT_W    = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic                  busy_q, busy_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [SMI_DATA_W-2:0] cmd_q;
  logic [SMI_DATA_W-1:0] data_q, data_d;
  logic                  cmd_en, data_en, start, last, rd_done;
  cmd_word_t             cur;

  assign cur      = cmd_word_t'({busy_q, cmd_q});
  assign last     = busy_q && (cnt_q == CNT_LAST);
  assign xfer_we  = last && cur.c22 && (cur.op == OP_WR);
  assign rd_done  = last && cur.c22 && (cur.op == OP_RD);
  assign xfer_dev = cur.dev;
  assign xfer_reg = cur.regn;

  always_comb begin
    cmd_en  = cmd_wr && !busy_q;
    start   = cmd_en && wdata[SMI_DATA_W-1];
    data_en = (data_wr && !busy_q) || rd_done;
    data_d  = rd_done ? dev_rdata : wdata;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (busy_q) begin
      cnt_d = cnt_q - CNT_LAST;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (cmd_en)  cmd_q  <= wdata[SMI_DATA_W-2:0];
      if (data_en) data_q <= data_d;
    end
  end

  assign cmd_rdata  = {busy_q, cmd_q};
  assign data_rdata = data_q;
  assign busy       = busy_q;

  AST_CMD_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cmd_wr |=> $stable(cmd_q)); // R7
  AST_DATA_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && data_wr && !rd_done |=> $stable(data_q)); // R7
  AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(cmd_wr && wdata[SMI_DATA_W-1])); // R6

endmodule

// File: rtl/smi_addr_window.sv
module smi_addr_window
  import smi_win_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 4,
  parameter int unsigned STORE_REG_W = 2,
  parameter bit          DUAL_WINDOW = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            strap_hi,
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic [4:0]            acc_phy,
  input  logic [4:0]            acc_reg,
  input  logic [15:0]           acc_wdata,
  output logic                  rsp_valid,
  output logic [15:0]           rsp_data
);

  logic                  hit_direct, hit_window;
  logic [SMI_ADDR_W-1:0] dev_idx;
  logic                  cmd_wr, data_wr, dir_we, mem_we;
  logic                  xfer_we, eng_busy;
  logic [SMI_ADDR_W-1:0] xfer_dev, xfer_reg;
  logic [SMI_DATA_W-1:0] dir_rdata, eng_rdata, cmd_rdata, data_rdata;
  logic [SMI_ADDR_W-1:0] mem_wdev;
  logic [STORE_REG_W-1:0] mem_wreg;
  logic [SMI_DATA_W-1:0] mem_wdata;
  logic                  rsp_valid_q, rsp_en;
  logic [SMI_DATA_W-1:0] rsp_data_q, rsp_data_d;
  logic                  unused_busy;

  smi_win_decode #(.DUAL_WINDOW(DUAL_WINDOW)) u_decode (
    .strap_hi   (strap_hi),
    .acc_phy    (acc_phy),
    .hit_direct (hit_direct),
    .hit_window (hit_window),
    .dev_idx    (dev_idx)
  );

  assign cmd_wr  = acc_valid && acc_write && hit_window && (acc_reg == WIN_CMD_REG);
  assign data_wr = acc_valid && acc_write && hit_window && (acc_reg == WIN_DATA_REG);
  assign dir_we  = acc_valid && acc_write && hit_direct;

  smi_win_engine #(.BUSY_CYCLES(BUSY_CYCLES)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .data_wr    (data_wr),
    .wdata      (acc_wdata),
    .dev_rdata  (eng_rdata),
    .cmd_rdata  (cmd_rdata),
    .data_rdata (data_rdata),
    .xfer_we    (xfer_we),
    .xfer_dev   (xfer_dev),
    .xfer_reg   (xfer_reg),
    .busy       (eng_busy)
  );
  assign unused_busy = eng_busy;

  // Engine completion takes the single store write port over a direct write.
  always_comb begin
    mem_we    = xfer_we || dir_we;
    mem_wdev  = xfer_we ? xfer_dev : dev_idx;
    mem_wreg  = xfer_we ? xfer_reg[STORE_REG_W-1:0] : acc_reg[STORE_REG_W-1:0];
    mem_wdata = xfer_we ? data_rdata : acc_wdata;
  end

  smi_win_regs #(.STORE_REG_W(STORE_REG_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mem_we),
    .wdev    (mem_wdev),
    .wreg    (mem_wreg),
    .wdata   (mem_wdata),
    .a_dev   (dev_idx),
    .a_reg   (acc_reg[STORE_REG_W-1:0]),
    .a_rdata (dir_rdata),
    .b_dev   (xfer_dev),
    .b_reg   (xfer_reg[STORE_REG_W-1:0]),
    .b_rdata (eng_rdata)
  );

  always_comb begin
    rsp_en     = acc_valid && !acc_write;
    rsp_data_d = NO_ANSWER;
    if (hit_direct) begin
      rsp_data_d = dir_rdata;
    end else if (hit_window) begin
      if (acc_reg == WIN_CMD_REG)       rsp_data_d = cmd_rdata;
      else if (acc_reg == WIN_DATA_REG) rsp_data_d = data_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_en;
      if (rsp_en) rsp_data_q <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_valid && !acc_write)); // R10
  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write && !hit_direct && !hit_window |=> rsp_data == 16'hFFFF); // R2

endmodule

// File: tb/smi_addr_window_bench.sv
module smi_addr_window_bench;

  localparam int BUSY = 4;

  logic        clk, rst_n;
  logic [3:0]  a_strap, b_strap;
  logic        a_valid, a_write, b_valid, b_write;
  logic [4:0]  a_phy, a_reg, b_phy, b_reg;
  logic [15:0] a_wdata, b_wdata;
  logic        a_rsp_valid, b_rsp_valid;
  logic [15:0] a_rsp_data, b_rsp_data;

  int checks = 0;
  int errors = 0;
  logic [15:0] qa_exp[$];
  string       qa_tag[$];
  logic [15:0] qb_exp[$];
  string       qb_tag[$];

  smi_addr_window #(.BUSY_CYCLES(BUSY), .STORE_REG_W(2), .DUAL_WINDOW(1'b0)) u_smi_addr_window (
    .clk(clk), .rst_n(rst_n), .strap_hi(a_strap), .acc_valid(a_valid), .acc_write(a_write),
    .acc_phy(a_phy), .acc_reg(a_reg), .acc_wdata(a_wdata),
    .rsp_valid(a_rsp_valid), .rsp_data(a_rsp_data));

  smi_addr_window #(.BUSY_CYCLES(BUSY), .STORE_REG_W(2), .DUAL_WINDOW(1'b1)) u_smi_addr_window_dual (
    .clk(clk), .rst_n(rst_n), .strap_hi(b_strap), .acc_valid(b_valid), .acc_write(b_write),
    .acc_phy(b_phy), .acc_reg(b_reg), .acc_wdata(b_wdata),
    .rsp_valid(b_rsp_valid), .rsp_data(b_rsp_data));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Monitors: pop one expected item per response, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && a_rsp_valid) begin
      checks++;
      if (qa_exp.size() == 0) begin
        errors++;
        $display("FAIL R10 single: unexpected response actual=%h expected=none", a_rsp_data);
      end else begin
        logic [15:0] e;
        string t;
        e = qa_exp.pop_front();
        t = qa_tag.pop_front();
        if (a_rsp_data !== e) begin
          errors++;
          $display("FAIL %s single: actual=%h expected=%h", t, a_rsp_data, e);
        end
      end
    end
    if (rst_n && b_rsp_valid) begin
      checks++;
      if (qb_exp.size() == 0) begin
        errors++;
        $display("FAIL R10 dual: unexpected response actual=%h expected=none", b_rsp_data);
      end else begin
        logic [15:0] e;
        string t;
        e = qb_exp.pop_front();
        t = qb_tag.pop_front();
        if (b_rsp_data !== e) begin
          errors++;
          $display("FAIL %s dual: actual=%h expected=%h", t, b_rsp_data, e);
        end
      end
    end
  end

  // One access per cycle; a read queues its expected response.
  task automatic acc(input bit dual, input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                     input logic [15:0] wd, input logic [15:0] exp, input string tag);
    if (!dual) begin
      a_valid = 1'b1; a_write = wr; a_phy = phy; a_reg = rg; a_wdata = wd;
      if (!wr) begin qa_exp.push_back(exp); qa_tag.push_back(tag); end
    end else begin
      b_valid = 1'b1; b_write = wr; b_phy = phy; b_reg = rg; b_wdata = wd;
      if (!wr) begin qb_exp.push_back(exp); qb_tag.push_back(tag); end
    end
    @(posedge clk); #1;
    a_valid = 1'b0;
    b_valid = 1'b0;
  endtask

  task automatic wr_a(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    acc(1'b0, 1'b1, phy, rg, wd, 16'h0, "");
  endtask
  task automatic rd_a(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] exp, input string tag);
    acc(1'b0, 1'b0, phy, rg, 16'h0, exp, tag);
  endtask
  task automatic wr_b(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    acc(1'b1, 1'b1, phy, rg, wd, 16'h0, "");
  endtask
  task automatic rd_b(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] exp, input string tag);
    acc(1'b1, 1'b0, phy, rg, 16'h0, exp, tag);
  endtask
  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a_strap = 4'h0; b_strap = 4'h8;
    a_valid = 0; a_write = 0; a_phy = 0; a_reg = 0; a_wdata = 0;
    b_valid = 0; b_write = 0; b_phy = 0; b_reg = 0; b_wdata = 0;
    idle(3);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (a_rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: rsp_valid actual=%b expected=0", a_rsp_valid);
    end
    @(posedge clk); #1;

    // Direct mapping, straps zero
    rd_a(5'd3, 5'd2, 16'h0000, "R8");
    wr_a(5'd0, 5'd0, 16'h1111);
    wr_a(5'd31, 5'd3, 16'hABCD);
    wr_a(5'd17, 5'd2, 16'h5A5A);
    rd_a(5'd0, 5'd0, 16'h1111, "R1");
    rd_a(5'd31, 5'd3, 16'hABCD, "R1");
    rd_a(5'd17, 5'd2, 16'h5A5A, "R1");
    rd_a(5'd16, 5'd2, 16'h0000, "R1");
    wr_a(5'd5, 5'd6, 16'h1234);
    rd_a(5'd5, 5'd2, 16'h1234, "R12");
    idle(2);

    // Indirect window at address 6
    a_strap = 4'b0011;
    idle(1);
    rd_a(5'd6, 5'd0, 16'h0000, "R8");
    rd_a(5'd6, 5'd1, 16'h0000, "R8");
    rd_a(5'd0, 5'd0, 16'hFFFF, "R2");
    rd_a(5'd7, 5'd0, 16'hFFFF, "R2");
    wr_a(5'd0, 5'd0, 16'h9999);
    wr_a(5'd7, 5'd0, 16'h9521);
    rd_a(5'd6, 5'd0, 16'h0000, "R2");
    rd_a(5'd6, 5'd5, 16'hFFFF, "R11");
    wr_a(5'd6, 5'd2, 16'h7777);
    rd_a(5'd6, 5'd1, 16'h0000, "R11");
    rd_a(5'd6, 5'd0, 16'h0000, "R11");

    // R4 indirect write of dev 9 reg 1, with R6 busy window
    wr_a(5'd6, 5'd1, 16'hBEEF);
    wr_a(5'd6, 5'd0, 16'h9521);
    for (int i = 0; i < BUSY; i++) rd_a(5'd6, 5'd0, 16'h9521, "R6");
    rd_a(5'd6, 5'd0, 16'h1521, "R3");
    wr_a(5'd6, 5'd1, 16'h0000);

    // R5 indirect read of dev 9 reg 1
    wr_a(5'd6, 5'd0, 16'h9921);
    idle(BUSY + 1);
    rd_a(5'd6, 5'd1, 16'hBEEF, "R5");
    rd_a(5'd6, 5'd0, 16'h1921, "R3");

    // R7 writes during busy ignored
    wr_a(5'd6, 5'd1, 16'h0042);
    wr_a(5'd6, 5'd0, 16'h9443);
    wr_a(5'd6, 5'd0, 16'h9921);
    wr_a(5'd6, 5'd1, 16'hDEAD);
    idle(BUSY + 1);
    rd_a(5'd6, 5'd0, 16'h1443, "R7");
    rd_a(5'd6, 5'd1, 16'h0042, "R7");
    wr_a(5'd6, 5'd1, 16'h0000);
    wr_a(5'd6, 5'd0, 16'h9843);
    idle(BUSY + 1);
    rd_a(5'd6, 5'd1, 16'h0042, "R7");
    idle(2);

    // Back to direct mapping: internal results visible
    a_strap = 4'h0;
    idle(1);
    rd_a(5'd9, 5'd1, 16'hBEEF, "R4");
    rd_a(5'd2, 5'd3, 16'h0042, "R4");
    rd_a(5'd0, 5'd0, 16'h1111, "R2");
    rd_a(5'd6, 5'd2, 16'h0000, "R11");

    // Dual-window build, base 16
    wr_b(5'd16, 5'd0, 16'h0101);
    wr_b(5'd31, 5'd1, 16'h3131);
    rd_b(5'd16, 5'd0, 16'h0101, "R9");
    rd_b(5'd31, 5'd1, 16'h3131, "R9");
    rd_b(5'd3, 5'd0, 16'hFFFF, "R9");
    wr_b(5'd3, 5'd0, 16'hEEEE);
    idle(2);
    b_strap = 4'b0110;
    idle(1);
    rd_b(5'd0, 5'd0, 16'h0101, "R9");
    rd_b(5'd15, 5'd1, 16'h3131, "R9");
    rd_b(5'd3, 5'd0, 16'h0000, "R9");
    rd_b(5'd16, 5'd0, 16'hFFFF, "R9");

    idle(4);
    checks++;
    if (qa_exp.size() != 0 || qb_exp.size() != 0) begin
      errors++;
      $display("FAIL R10 missing responses: actual=%0d/%0d pending expected=0/0",
               qa_exp.size(), qb_exp.size());
    end
    summary();
    $finish;
  end

endmodule